// File: doc/BRIEF.md
# Conflict Bypass Line Buffer

This block is a small, fully associative store of whole cache lines that sits next to a set-associative cache. When a refill arrives for a set whose ways cannot be safely evicted (the judgement is made elsewhere and arrives as a per-fill flag), the line is written here instead of into the cache. Every access probes this store alongside the cache probe. A hit is resolved combinationally from the request, so the data is ready in the same cycle a cache hit would deliver it.

Entries are replaced in least-recently-used order. A fill for a line already held updates that entry in place, so a line is never held twice. A modified line pushed out by replacement leaves through a writeback port with a valid/ready handshake. Further fills are held off until that writeback has been taken. An invalidate port removes a line and reports in the same cycle whether it was modified. The cache asserts its own hit flag on the lookup port, and the block raises an error if both structures claim the same access. All addresses on the ports are line addresses (byte address divided by the line size). The entry count must be a power of two of at least 2. The line size (32, 64 or 128 bytes, or other powers of two) sets the data width.

Top module: `conflict_bypass_buf`

## Requirements
- R1: After reset no line is held: every lookup misses, `fill_ready` is 1 and `wb_valid` is 0.
- R2: When `lk_valid` is 1 and `lk_line` equals the line address of a held entry, `lk_hit` is 1 and `lk_data` carries that entry's data in the same cycle, with no clock edge in between; otherwise `lk_hit` is 0.
- R3: `lk_dual_err` is 1 exactly when a lookup hits in this buffer while `lk_cache_hit` is 1.
- R4: A fill is taken on a rising edge when `fill_valid`, `fill_bypass` and `fill_ready` are all 1; a fill with `fill_bypass` at 0 changes no entry.
- R5: A taken fill whose line is already held overwrites that entry's data, ORs `fill_dirty` into its modified flag and evicts nothing, so a line is never held twice.
- R6: A taken fill for a new line uses a free entry while one exists, so up to the entry count of distinct lines stay resident together.
- R7: With every entry in use, a new line replaces the entry whose last touch (a taken fill, or a lookup hit in a cycle with no taken fill) is the oldest.
- R8: A replaced entry whose modified flag is set appears on `wb_valid`, `wb_line` and `wb_data` from the edge after the fill. It holds stable until a cycle with `wb_ready` at 1. A replaced clean entry is dropped without a writeback.
- R9: `fill_ready` is 0 while `wb_valid` is 1 or `inv_valid` is 1, and 1 otherwise.
- R10: When `inv_valid` is 1 and `inv_line` is held, `inv_hit` is 1 and `inv_dirty` shows that entry's modified flag in the same cycle; the entry is gone from the next edge on. An invalidate of a line not held gives `inv_hit` 0 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_line | input | LINE_W | Line address probed |
| lk_cache_hit | input | 1 | The companion cache hit on the same probe |
| lk_hit | output | 1 | Probe found in this buffer |
| lk_data | output | LINE_BYTES*8 | Line data on a hit, zero otherwise |
| lk_dual_err | output | 1 | Both the cache and this buffer hit |
| fill_valid | input | 1 | Refill present |
| fill_bypass | input | 1 | Refill must be placed here instead of the cache |
| fill_line | input | LINE_W | Line address of the refill |
| fill_data | input | LINE_BYTES*8 | Refill data |
| fill_dirty | input | 1 | Refill line is modified |
| fill_ready | output | 1 | A refill can be taken this cycle |
| inv_valid | input | 1 | Invalidate request |
| inv_line | input | LINE_W | Line address to invalidate |
| inv_hit | output | 1 | The line was held |
| inv_dirty | output | 1 | The invalidated line was modified |
| wb_valid | output | 1 | Modified victim waiting for writeback |
| wb_line | output | LINE_W | Victim line address |
| wb_data | output | LINE_BYTES*8 | Victim data |
| wb_ready | input | 1 | Writeback taken |

## Verification
The hardest case to reach from the ports is a modified victim being replaced while other traffic continues. The writeback must then stay stable, fills must stall, and the replacement order must keep tracking lookups that hit during the stall. The bench uses a four-entry configuration and draws operations from a pool of six lines. This forces evictions constantly, and mixed modified and clean fills, hitting lookups and delayed `wb_ready` pulses create writebacks that remain pending across several cycles. A timestamp model in the bench chooses every victim independently of the buffer's age counters.

// File: rtl/cbb_pkg.sv
package cbb_pkg;
  // How a taken fill is placed.
  typedef enum logic [1:0] {
    FILL_NONE  = 2'd0,
    FILL_MERGE = 2'd1,
    FILL_FREE  = 2'd2,
    FILL_EVICT = 2'd3
  } fill_kind_e;

  // Age of an entry after a touch: the touched entry becomes youngest,
  // entries younger than it grow one step older, the rest keep their age.
  function automatic logic [7:0] age_after_touch(input logic [7:0] age,
                                                 input logic [7:0] touched_age,
                                                 input logic       is_touched);
    if (is_touched)              return 8'd0;
    else if (age < touched_age)  return age + 8'd1;
    else                         return age;
  endfunction
endpackage

// File: rtl/cbb_match.sv
module cbb_match #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned TAG_W   = 26,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]            valid,
  input  logic [ENTRIES-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]              probe,
  output logic [ENTRIES-1:0]            hit_vec,
  output logic                          hit,
  output logic [IDX_W-1:0]              idx
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = valid[g] && (tags[g] == probe);
  end

  assign hit = |hit_vec;

  // OR encoder: exact for a one-hot vector, which allocation guarantees.
  always_comb begin
    idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit_vec[i]) idx = idx | IDX_W'(i);
  end
endmodule

// File: rtl/cbb_lru.sv
module cbb_lru #(
  parameter int unsigned ENTRIES = 16,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] victim_idx
);
  logic [IDX_W-1:0]   age_q [ENTRIES];
  logic [ENTRIES-1:0] oldest_vec;
  logic [IDX_W-1:0]   touched_age;

  assign touched_age = age_q[touch_idx];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_age
    assign oldest_vec[g] = (age_q[g] == IDX_W'(ENTRIES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        age_q[g] <= IDX_W'(g);
      else if (touch_en)
        age_q[g] <= IDX_W'(cbb_pkg::age_after_touch(8'(age_q[g]), 8'(touched_age),
                                                    touch_idx == IDX_W'(g)));
    end
  end

  always_comb begin
    victim_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (oldest_vec[i]) victim_idx = victim_idx | IDX_W'(i);
  end

  // Ages stay a permutation, so exactly one entry is oldest.
  p_single_oldest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest_vec) == 1);

  // A touched entry is the youngest right after the touch.
  p_touch_youngest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> age_q[$past(touch_idx)] == '0);
endmodule

// File: rtl/cbb_wb_slot.sv
module cbb_wb_slot #(
  parameter int unsigned LINE_W = 26,
  parameter int unsigned DATA_W = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [LINE_W-1:0] load_line,
  input  logic [DATA_W-1:0] load_data,
  input  logic              wb_ready,
  output logic              wb_valid,
  output logic [LINE_W-1:0] wb_line,
  output logic [DATA_W-1:0] wb_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wb_valid <= 1'b0;
    else if (load)     wb_valid <= 1'b1;
    else if (wb_ready) wb_valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      wb_line <= load_line;
      wb_data <= load_data;
    end
  end

  p_wb_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_line) && $stable(wb_data)));

  p_no_overrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !wb_valid);
endmodule

// File: rtl/conflict_bypass_buf.sv
module conflict_bypass_buf #(
  parameter int unsigned ENTRIES    = 16,
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned LINE_W     = 26,
  localparam int unsigned IDX_W     = $clog2(ENTRIES),
  localparam int unsigned DATA_W    = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [LINE_W-1:0] lk_line,
  input  logic              lk_cache_hit,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data,
  output logic              lk_dual_err,
  input  logic              fill_valid,
  input  logic              fill_bypass,
  input  logic [LINE_W-1:0] fill_line,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              fill_dirty,
  output logic              fill_ready,
  input  logic              inv_valid,
  input  logic [LINE_W-1:0] inv_line,
  output logic              inv_hit,
  output logic              inv_dirty,
  output logic              wb_valid,
  output logic [LINE_W-1:0] wb_line,
  output logic [DATA_W-1:0] wb_data,
  input  logic              wb_ready
);
  import cbb_pkg::*;

  // Entry state
  logic [ENTRIES-1:0]             valid_q;
  logic [ENTRIES-1:0]             dirty_q;
  logic [ENTRIES-1:0][LINE_W-1:0] tag_q;
  logic [DATA_W-1:0]              data_q [ENTRIES];

  // Named internal events
  logic [ENTRIES-1:0] lk_vec, fl_vec, iv_vec;
  logic               lk_match, fl_match, iv_match;
  logic [IDX_W-1:0]   lk_idx, fl_idx, iv_idx;
  logic               any_free;
  logic [IDX_W-1:0]   free_idx;
  logic [IDX_W-1:0]   victim_idx;
  logic               fill_fire;
  fill_kind_e         fill_kind;
  logic [IDX_W-1:0]   fill_idx;
  logic               evict_dirty;
  logic               inv_fire;
  logic               touch_en;
  logic [IDX_W-1:0]   touch_idx;

  cbb_match #(.ENTRIES(ENTRIES), .TAG_W(LINE_W)) u_lk_match (
    .valid(valid_q), .tags(tag_q), .probe(lk_line),
    .hit_vec(lk_vec), .hit(lk_match), .idx(lk_idx));

  cbb_match #(.ENTRIES(ENTRIES), .TAG_W(LINE_W)) u_fl_match (
    .valid(valid_q), .tags(tag_q), .probe(fill_line),
    .hit_vec(fl_vec), .hit(fl_match), .idx(fl_idx));

  cbb_match #(.ENTRIES(ENTRIES), .TAG_W(LINE_W)) u_iv_match (
    .valid(valid_q), .tags(tag_q), .probe(inv_line),
    .hit_vec(iv_vec), .hit(iv_match), .idx(iv_idx));

  // Lookup path: purely combinational so the hit lands in the probe cycle.
  assign lk_hit      = lk_valid && lk_match;
  assign lk_data     = lk_hit ? data_q[lk_idx] : '0;
  assign lk_dual_err = lk_hit && lk_cache_hit;

  // Invalidate path
  assign inv_hit   = inv_valid && iv_match;
  assign inv_dirty = inv_hit && dirty_q[iv_idx];
  assign inv_fire  = inv_hit;

  // Lowest free entry
  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_q[i]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  // Fill placement
  assign fill_ready = !wb_valid && !inv_valid;
  assign fill_fire  = fill_valid && fill_bypass && fill_ready;

  always_comb begin
    fill_kind = FILL_NONE;
    fill_idx  = '0;
    if (fill_fire) begin
      if (fl_match) begin
        fill_kind = FILL_MERGE;
        fill_idx  = fl_idx;
      end else if (any_free) begin
        fill_kind = FILL_FREE;
        fill_idx  = free_idx;
      end else begin
        fill_kind = FILL_EVICT;
        fill_idx  = victim_idx;
      end
    end
  end

  assign evict_dirty = (fill_kind == FILL_EVICT) && dirty_q[victim_idx];

  // Replacement order: a taken fill wins over a lookup hit in the same cycle.
  assign touch_en  = fill_fire || lk_hit;
  assign touch_idx = fill_fire ? fill_idx : lk_idx;

  cbb_lru #(.ENTRIES(ENTRIES)) u_lru (
    .clk(clk), .rst_n(rst_n),
    .touch_en(touch_en), .touch_idx(touch_idx),
    .victim_idx(victim_idx));

  cbb_wb_slot #(.LINE_W(LINE_W), .DATA_W(DATA_W)) u_wb (
    .clk(clk), .rst_n(rst_n),
    .load(evict_dirty),
    .load_line(tag_q[victim_idx]),
    .load_data(data_q[victim_idx]),
    .wb_ready(wb_ready),
    .wb_valid(wb_valid), .wb_line(wb_line), .wb_data(wb_data));

  // Control state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (fill_kind != FILL_NONE) begin
      valid_q[fill_idx] <= 1'b1;
      dirty_q[fill_idx] <= (fill_kind == FILL_MERGE) ? (dirty_q[fill_idx] | fill_dirty)
                                                      : fill_dirty;
    end else if (inv_fire) begin
      valid_q[iv_idx] <= 1'b0;
      dirty_q[iv_idx] <= 1'b0;
    end
  end

  // Payload state, no reset needed
  always_ff @(posedge clk) begin
    if (fill_fire) begin
      tag_q[fill_idx]  <= fill_line;
      data_q[fill_idx] <= fill_data;
    end
  end

  // R5: a line is never held in two entries.
  p_no_dup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_vec) && $onehot0(fl_vec) && $onehot0(iv_vec));

  // R4: a taken fill leaves its line resident in the chosen entry.
  p_fill_resident_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_fire |=> (valid_q[$past(fill_idx)] && tag_q[$past(fill_idx)] == $past(fill_line)));

  // R10: an invalidated entry is gone on the next edge.
  p_inv_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    inv_fire |=> !valid_q[$past(iv_idx)]);

  // R6: eviction only happens with every entry in use.
  p_evict_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_kind == FILL_EVICT) |-> (&valid_q));
endmodule

// File: tb/tb_conflict_bypass_buf.sv
module tb_conflict_bypass_buf;
  localparam int N  = 4;
  localparam int LB = 32;
  localparam int LW = 8;
  localparam int DW = LB * 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lk_valid = 0, lk_cache_hit = 0;
  logic [LW-1:0] lk_line = '0;
  logic          lk_hit, lk_dual_err;
  logic [DW-1:0] lk_data;
  logic          fill_valid = 0, fill_bypass = 0, fill_dirty = 0;
  logic [LW-1:0] fill_line = '0;
  logic [DW-1:0] fill_data = '0;
  logic          fill_ready;
  logic          inv_valid = 0;
  logic [LW-1:0] inv_line = '0;
  logic          inv_hit, inv_dirty;
  logic          wb_valid, wb_ready = 0;
  logic [LW-1:0] wb_line;
  logic [DW-1:0] wb_data;

  always #4 clk = ~clk;

  conflict_bypass_buf #(.ENTRIES(N), .LINE_BYTES(LB), .LINE_W(LW)) dut (
    .clk, .rst_n, .lk_valid, .lk_line, .lk_cache_hit, .lk_hit, .lk_data, .lk_dual_err,
    .fill_valid, .fill_bypass, .fill_line, .fill_data, .fill_dirty, .fill_ready,
    .inv_valid, .inv_line, .inv_hit, .inv_dirty,
    .wb_valid, .wb_line, .wb_data, .wb_ready);

  int nchk = 0, nerr = 0;

  // Reference model: timestamps instead of age counters.
  bit            m_v [N];
  logic [LW-1:0] m_line [N];
  logic [DW-1:0] m_data [N];
  bit            m_dirty [N];
  int            m_stamp [N];
  int            now = 0;
  bit            wbp = 0;
  logic [LW-1:0] wbp_line;
  logic [DW-1:0] wbp_data;
  int            dseq = 0;

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int find(input logic [LW-1:0] l);
    for (int i = 0; i < N; i++) if (m_v[i] && m_line[i] == l) return i;
    return -1;
  endfunction

  function automatic logic [DW-1:0] gen_data(input int s);
    logic [31:0] w;
    w = (32'(s) * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    return {8{w}};
  endfunction

  task automatic op_lookup(input logic [LW-1:0] l, input bit ch);
    int k;
    @(negedge clk);
    lk_valid = 1; lk_line = l; lk_cache_hit = ch;
    #1;
    k = find(l);
    chk(lk_hit == (k >= 0), "R2 lookup hit", DW'(lk_hit), DW'(k >= 0));
    if (k >= 0) chk(lk_data == m_data[k], "R2 lookup data", lk_data, m_data[k]);
    chk(lk_dual_err == (k >= 0 && ch), "R3 dual hit flag", DW'(lk_dual_err), DW'(k >= 0 && ch));
    @(posedge clk); #1;
    lk_valid = 0; lk_cache_hit = 0;
    if (k >= 0) begin now++; m_stamp[k] = now; end
  endtask

  task automatic op_fill(input logic [LW-1:0] l, input bit d, input bit byp);
    int k, v;
    logic [DW-1:0] dat;
    dseq++;
    dat = gen_data(dseq);
    @(negedge clk);
    fill_valid = 1; fill_bypass = byp; fill_line = l; fill_dirty = d; fill_data = dat;
    #1;
    chk(fill_ready == !wbp, "R9 fill_ready", DW'(fill_ready), DW'(!wbp));
    @(posedge clk); #1;
    fill_valid = 0; fill_bypass = 0;
    if (byp && !wbp) begin
      now++;
      k = find(l);
      if (k >= 0) begin
        m_data[k] = dat; m_dirty[k] = m_dirty[k] | d; m_stamp[k] = now;
      end else begin
        v = -1;
        for (int i = 0; i < N; i++) if (!m_v[i] && v < 0) v = i;
        if (v < 0) begin
          v = 0;
          for (int i = 1; i < N; i++) if (m_stamp[i] < m_stamp[v]) v = i;
          if (m_dirty[v]) begin wbp = 1; wbp_line = m_line[v]; wbp_data = m_data[v]; end
        end
        m_v[v] = 1; m_line[v] = l; m_data[v] = dat; m_dirty[v] = d; m_stamp[v] = now;
      end
    end
  endtask

  task automatic op_inv(input logic [LW-1:0] l);
    int k;
    @(negedge clk);
    inv_valid = 1; inv_line = l;
    #1;
    k = find(l);
    chk(inv_hit == (k >= 0), "R10 inv_hit", DW'(inv_hit), DW'(k >= 0));
    chk(inv_dirty == (k >= 0 && m_dirty[k]), "R10 inv_dirty", DW'(inv_dirty), DW'(k >= 0 && m_dirty[k]));
    chk(fill_ready == 1'b0, "R9 ready low during invalidate", DW'(fill_ready), DW'(0));
    @(posedge clk); #1;
    inv_valid = 0;
    if (k >= 0) begin m_v[k] = 0; m_dirty[k] = 0; end
  endtask

  task automatic op_wb(input bit rdy);
    @(negedge clk);
    wb_ready = rdy;
    #1;
    chk(wb_valid == wbp, "R8 wb_valid", DW'(wb_valid), DW'(wbp));
    if (wbp) begin
      chk(wb_line == wbp_line, "R8 wb_line", DW'(wb_line), DW'(wbp_line));
      chk(wb_data == wbp_data, "R8 wb_data", wb_data, wbp_data);
    end
    @(posedge clk); #1;
    wb_ready = 0;
    if (rdy) wbp = 0;
  endtask

  // Watchdog
  initial begin
    #(8 * 200000);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [31:0] rnd;
    rnd = 32'h1234_5678;
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_dirty[i] = 0; m_stamp[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: empty after reset
    #1;
    chk(fill_ready == 1'b1, "R1 ready after reset", DW'(fill_ready), DW'(1));
    chk(wb_valid == 1'b0, "R1 no writeback after reset", DW'(wb_valid), DW'(0));
    for (int l = 0; l < 8; l++) op_lookup(LW'(8'h10 + l), 1'b0);

    // R4: fill without the bypass request is ignored
    op_fill(8'h10, 1'b1, 1'b0);
    op_lookup(8'h10, 1'b0);

    // R6: four lines stay resident
    op_fill(8'h10, 1'b0, 1'b1);
    op_fill(8'h11, 1'b1, 1'b1);
    op_fill(8'h12, 1'b0, 1'b1);
    op_fill(8'h13, 1'b0, 1'b1);
    for (int l = 0; l < 4; l++) op_lookup(LW'(8'h10 + l), 1'b0);
    // R3: hit in both structures
    op_lookup(8'h12, 1'b1);
    // R7: refresh 0x10, 0x11 becomes oldest; a new line evicts it (dirty -> R8)
    op_lookup(8'h10, 1'b0);
    op_lookup(8'h13, 1'b0);
    op_lookup(8'h12, 1'b0);
    op_fill(8'h14, 1'b0, 1'b1);
    op_lookup(8'h11, 1'b0);
    op_wb(1'b0);
    op_wb(1'b0);
    // R9: fill stalls while writeback pending
    op_fill(8'h15, 1'b0, 1'b1);
    op_lookup(8'h15, 1'b0);
    op_wb(1'b1);
    op_wb(1'b0);
    // R5: refill of a held line merges in place
    op_fill(8'h12, 1'b1, 1'b1);
    op_lookup(8'h12, 1'b0);
    for (int l = 0; l < 6; l++) op_lookup(LW'(8'h10 + l), 1'b0);
    // R10: invalidate a dirty line, a clean one and an absent one
    op_inv(8'h12);
    op_inv(8'h13);
    op_inv(8'h17);
    op_lookup(8'h12, 1'b0);

    // Near-exhaustive mixed sweep over six lines
    for (int n = 0; n < 4000; n++) begin
      logic [LW-1:0] l;
      rnd = rnd ^ (rnd << 13); rnd = rnd ^ (rnd >> 17); rnd = rnd ^ (rnd << 5);
      l = LW'(8'h10 + (rnd[15:8] % 6));
      case (rnd[2:0])
        3'd0, 3'd1, 3'd2: op_fill(l, rnd[20], rnd[21] | rnd[22]);
        3'd3, 3'd4:       op_lookup(l, rnd[23]);
        3'd5:             op_inv(l);
        default:          op_wb(rnd[24]);
      endcase
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule